// File: doc/BRIEF.md
# EDO DRAM access controller

This block sits between a simple synchronous request port and an asynchronous 2M x 8 extended-data-out DRAM whose address pins are shared by the row and the column. Each accepted request carries a write flag, a 21-bit byte address and, for writes, one byte of data. The controller splits the address into an 11-bit row and a 10-bit column. It opens the row with a RAS fall, strobes the column with CAS, and returns read bytes on a one-cycle read-valid strobe.

Every analog timing limit becomes a whole number of clock cycles, given as a parameter and rounded up from nanoseconds at the clock period in use. After a transfer the row stays open. Later requests to the same row then need only a CAS pulse. The page closes on a row miss, on a refresh request, or when the RAS-low timer comes near the parameterised maximum. Writes are always early writes: WE falls before CAS, so the DRAM never drives its data pins. Read data is captured after CAS has risen again, which relies on the extended-data-out hold. An external refresher gets the memory through a request/grant pair, and only once the page is closed and fully precharged.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, dram_ras_n, dram_cas_n, dram_we_n and dram_oe_n are 1, dram_dq_oe is 0, rd_valid is 0 and req_ready is 0.
- R2: With ROW_HIGH=1, the row is req_addr[20:10] and appears on dram_addr[10:0] when RAS falls. The column is req_addr[9:0] and appears on dram_addr[9:0], with bit 10 at 0, when CAS falls.
- R3: RAS stays high for at least T_RP cycles before each fall. Each RAS-low period lasts at least T_RAS cycles.
- R4: No RAS-low period exceeds RAS_MAX cycles.
- R5: CAS falls only while RAS is low, and at least T_RCD cycles after RAS fell. The row stays on dram_addr for the first T_RAH cycles of RAS low.
- R6: Each CAS-low pulse lasts at least T_CAS cycles. CAS stays high for at least T_CP cycles between pulses. Successive CAS falls are at least T_PC cycles apart.
- R7: For a write, dram_we_n is 0 in the cycle before CAS falls and in the cycle in which it falls. dram_dq_oe is 1 with the request's byte on dram_dq_out, and dram_oe_n stays 1.
- R8: For a read, CAS is held low until it has been low for T_CAS cycles and RAS has been low for T_RAC cycles. The byte on dram_dq_in is captured one cycle after CAS rises and returned on rd_data, with rd_valid high for exactly one cycle, in request order.
- R9: Successive requests to the open row are served without a new RAS fall.
- R10: A request to a different row closes the page with a full precharge and activates the new row.
- R11: An open page is closed without any request once its RAS-low time reaches RAS_MAX minus (T_CAS + T_CP + 3) cycles. A long run of same-row requests is split across several activations.
- R12: ref_gnt is raised only with RAS and CAS high and at least T_RP cycles of precharge done. While it is high, req_ready is 0 and RAS stays high. After ref_req drops, a full precharge follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid, one-cycle pulse |
| rd_data | output | 8 | Read byte |
| ref_req | input | 1 | Refresher asks for the memory |
| ref_gnt | output | 1 | Memory handed to the refresher |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 8 | Data from the DRAM |

## Verification
The bench keeps the default timing counts for a 250 MHz clock (T_RP=10, T_RAS=15, T_RAH=3, T_RCD=4, T_CAS=4, T_CP=3, T_RAC=15, T_PC=7). It lowers RAS_MAX to 80, so the page-close guard trips after about 70 cycles of RAS low. That brings idle time-outs and forced splits of long same-row bursts within a few hundred cycles. The DRAM model drives garbage until both CAS-access and RAS-access counts are met, so a read strobed too briefly returns a wrong byte.

// File: rtl/edo_pkg.sv
package edo_pkg;

   typedef enum logic [2:0] {
      ST_PRE,
      ST_IDLE,
      ST_REF,
      ST_ACT,
      ST_COL,
      ST_CASL,
      ST_CASH,
      ST_OPEN
   } edo_st_e;

   function automatic int edo_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/edo_addr_map.sv
module edo_addr_map #(
   parameter int ADDR_W   = 21,
   parameter int ROW_W    = 11,
   parameter int COL_W    = 10,
   parameter bit ROW_HIGH = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col
);

   if (ROW_W + COL_W != ADDR_W) begin : g_bad_split
      $error("edo_addr_map: ROW_W + COL_W must equal ADDR_W");
   end

   if (ROW_HIGH) begin : g_row_top
      assign row = addr[ADDR_W-1 -: ROW_W];
      assign col = addr[COL_W-1:0];
   end else begin : g_row_bottom
      assign row = addr[ROW_W-1:0];
      assign col = addr[ADDR_W-1 -: COL_W];
   end

endmodule

// File: rtl/edo_phase_timer.sv
module edo_phase_timer #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] cnt_d
);

   localparam logic [CW-1:0] TOP = {CW{1'b1}};

   always_comb begin
      if (restart)           cnt_d = '0;
      else if (cnt_q == TOP) cnt_d = cnt_q;
      else                   cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

endmodule

// File: rtl/edo_ras_timer.sv
module edo_ras_timer #(
   parameter int RAS_MAX = 25000,
   parameter int T_RAS   = 15,
   parameter int T_RAC   = 15,
   parameter int GUARD   = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ras_n,
   output logic min_ok,
   output logic rac_ok,
   output logic near_max
);

   localparam int CW = $clog2(RAS_MAX + 2);
   localparam logic [CW-1:0] SAT = CW'(RAS_MAX + 1);

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              low_cnt <= '0;
      else if (ras_n)          low_cnt <= '0;
      else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
   end

   assign min_ok   = int'(low_cnt) >= T_RAS - 1;
   assign rac_ok   = int'(low_cnt) >= T_RAC - 1;
   assign near_max = int'(low_cnt) >= RAS_MAX - GUARD;

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
   import edo_pkg::*;
#(
   parameter int ADDR_W   = 21,
   parameter int ROW_W    = 11,
   parameter int COL_W    = 10,
   parameter int DATA_W   = 8,
   parameter bit ROW_HIGH = 1'b1,
   parameter int T_RP     = 10,
   parameter int T_RAS    = 15,
   parameter int T_RAH    = 3,
   parameter int T_RCD    = 4,
   parameter int T_CAS    = 4,
   parameter int T_CP     = 3,
   parameter int T_RAC    = 15,
   parameter int T_PC     = 7,
   parameter int RAS_MAX  = 25000,
   localparam int PIN_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ref_req,
   output logic              ref_gnt,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_oe_n,
   output logic [PIN_W-1:0]  dram_addr,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);

   localparam int GUARD  = T_CAS + T_CP + 3;
   localparam int PH_TOP = edo_max(edo_max(T_RP, T_RCD), edo_max(T_CAS, T_CP)) + 1;
   localparam int PH_W   = $clog2(PH_TOP + 1);

   if (T_RAH < 1 || T_RAH >= T_RCD) begin : g_bad_rah
      $error("edo_dram_ctrl: need 1 <= T_RAH < T_RCD for column setup");
   end
   if (T_RP < 1 || T_CAS < 1 || T_CP < 1) begin : g_bad_pulse
      $error("edo_dram_ctrl: pulse counts must be at least one cycle");
   end
   if (T_CAS + T_CP + 2 < T_PC) begin : g_bad_page
      $error("edo_dram_ctrl: page cycle too short for T_PC");
   end
   if (RAS_MAX <= GUARD + T_RCD + T_RAC + T_CP) begin : g_bad_max
      $error("edo_dram_ctrl: RAS_MAX too small for one access");
   end

   edo_st_e st_q, st_d;
   logic [PH_W-1:0]   ph_q, ph_d;
   logic [ROW_W-1:0]  req_row, row_q, row_d;
   logic [COL_W-1:0]  req_col, col_q, col_d;
   logic [DATA_W-1:0] wd_q, wd_d;
   logic              wr_q, wr_d;
   logic              ras_min_ok, ras_rac_ok, ras_near;
   logic              row_hit, accept;

   edo_addr_map #(
      .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .ROW_HIGH(ROW_HIGH)
   ) u_map (
      .addr(req_addr), .row(req_row), .col(req_col)
   );

   edo_phase_timer #(.CW(PH_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .restart(st_d != st_q),
      .cnt_q(ph_q), .cnt_d(ph_d)
   );

   edo_ras_timer #(
      .RAS_MAX(RAS_MAX), .T_RAS(T_RAS), .T_RAC(T_RAC), .GUARD(GUARD)
   ) u_ras (
      .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n),
      .min_ok(ras_min_ok), .rac_ok(ras_rac_ok), .near_max(ras_near)
   );

   assign row_hit = (req_row == row_q);
   assign accept  = req_valid && req_ready;

   // sequencing
   always_comb begin
      st_d      = st_q;
      req_ready = 1'b0;
      case (st_q)
         ST_PRE:  if (int'(ph_q) >= T_RP - 1) st_d = ST_IDLE;
         ST_IDLE: begin
            if (ref_req) st_d = ST_REF;
            else begin
               req_ready = 1'b1;
               if (req_valid) st_d = ST_ACT;
            end
         end
         ST_REF:  if (!ref_req) st_d = ST_PRE;
         ST_ACT:  if (int'(ph_q) >= T_RCD - 1) st_d = ST_CASL;
         ST_COL:  st_d = ST_CASL;
         ST_CASL: if (int'(ph_q) >= T_CAS - 1 && (wr_q || ras_rac_ok)) st_d = ST_CASH;
         ST_CASH: if (int'(ph_q) >= T_CP - 1) st_d = ST_OPEN;
         ST_OPEN: begin
            req_ready = !ref_req && !ras_near && row_hit;
            if (req_valid && req_ready) st_d = ST_COL;
            else if ((ref_req || ras_near || req_valid) && ras_min_ok) st_d = ST_PRE;
         end
         default: st_d = ST_PRE;
      endcase
   end

   // request capture
   always_comb begin
      row_d = row_q;
      col_d = col_q;
      wd_d  = wd_q;
      wr_d  = wr_q;
      if (accept) begin
         row_d = req_row;
         col_d = req_col;
         wd_d  = req_wdata;
         wr_d  = req_write;
      end
   end

   // pin values for the coming cycle
   logic              ras_low_d, col_phase_d, wr_drive_d;
   logic [PIN_W-1:0]  addr_d;

   always_comb begin
      ras_low_d   = (st_d == ST_ACT) || (st_d == ST_COL) || (st_d == ST_CASL) ||
                    (st_d == ST_CASH) || (st_d == ST_OPEN);
      col_phase_d = ((st_d == ST_ACT) && (int'(ph_d) >= T_RAH)) ||
                    (st_d == ST_COL) || (st_d == ST_CASL) || (st_d == ST_CASH);
      wr_drive_d  = wr_d && (((st_d == ST_ACT) && (int'(ph_d) >= T_RAH)) ||
                             (st_d == ST_COL) || (st_d == ST_CASL));
      addr_d      = col_phase_d ? PIN_W'(col_d) : PIN_W'(row_d);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_PRE;
         row_q       <= '0;
         col_q       <= '0;
         wd_q        <= '0;
         wr_q        <= 1'b0;
         dram_ras_n  <= 1'b1;
         dram_cas_n  <= 1'b1;
         dram_we_n   <= 1'b1;
         dram_oe_n   <= 1'b1;
         dram_addr   <= '0;
         dram_dq_out <= '0;
         dram_dq_oe  <= 1'b0;
         ref_gnt     <= 1'b0;
         rd_valid    <= 1'b0;
         rd_data     <= '0;
      end else begin
         st_q        <= st_d;
         row_q       <= row_d;
         col_q       <= col_d;
         wd_q        <= wd_d;
         wr_q        <= wr_d;
         dram_ras_n  <= !ras_low_d;
         dram_cas_n  <= !(st_d == ST_CASL);
         dram_we_n   <= !wr_drive_d;
         dram_oe_n   <= !(!wr_d && ((st_d == ST_CASL) || (st_d == ST_CASH)));
         dram_addr   <= addr_d;
         dram_dq_out <= wd_d;
         dram_dq_oe  <= wr_drive_d;
         ref_gnt     <= (st_d == ST_REF);
         rd_valid    <= (st_q == ST_CASH) && (ph_q == '0) && !wr_q;
         if ((st_q == ST_CASH) && (ph_q == '0) && !wr_q) rd_data <= dram_dq_in;
      end
   end

endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
   parameter int RAS_MAX = 25000,
   parameter int T_RAS   = 15
) (
   input logic clk,
   input logic rst_n,
   input logic ref_gnt,
   input logic req_ready,
   input logic rd_valid,
   input logic ras_n,
   input logic cas_n,
   input logic we_n,
   input logic oe_n,
   input logic dq_oe
);

   localparam int CW = $clog2(RAS_MAX + 2);
   localparam logic [CW-1:0] SAT = CW'(RAS_MAX + 1);

   logic [CW-1:0] lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             lo_cnt <= '0;
      else if (ras_n)         lo_cnt <= '0;
      else if (lo_cnt != SAT) lo_cnt <= lo_cnt + 1'b1;
   end

   assert_gnt_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ref_gnt |-> (ras_n && cas_n && !req_ready));

   assert_cas_in_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   assert_early_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n) && !we_n) |-> $past(!we_n));

   assert_write_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || dq_oe) |-> oe_n);

   assert_ras_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(lo_cnt) <= RAS_MAX);

   assert_ras_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> int'(lo_cnt) >= T_RAS);

   assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(.RAS_MAX(RAS_MAX), .T_RAS(T_RAS)) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .req_ready(req_ready),
   .rd_valid(rd_valid), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
   .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe)
);

// File: tb/edo_dram_ctrl_tb.sv
`timescale 1ns/1ps
module edo_dram_ctrl_tb;

   localparam int T_RP  = 10;
   localparam int T_RAS = 15;
   localparam int T_RAH = 3;
   localparam int T_RCD = 4;
   localparam int T_CAS = 4;
   localparam int T_CP  = 3;
   localparam int T_RAC = 15;
   localparam int T_PC  = 7;
   localparam int RMAX  = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [20:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rd_valid, ref_gnt;
   logic [7:0]  rd_data;
   logic        ref_req = 1'b0;
   logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
   logic [10:0] dram_addr;
   logic [7:0]  dram_dq_out;
   logic [7:0]  dram_dq_in = '0;

   always #2 clk = ~clk;

   edo_dram_ctrl #(
      .T_RP(T_RP), .T_RAS(T_RAS), .T_RAH(T_RAH), .T_RCD(T_RCD), .T_CAS(T_CAS),
      .T_CP(T_CP), .T_RAC(T_RAC), .T_PC(T_PC), .RAS_MAX(RMAX)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
      .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
      .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
   );

   int nchk = 0, nfail = 0;
   bit done = 1'b0;

   task automatic chk_eq(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_ge(input string tag, input int act, input int lim);
      nchk++;
      if (act < lim) begin
         nfail++;
         $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
      end
   endtask

   task automatic chk_le(input string tag, input int act, input int lim);
      nchk++;
      if (act > lim) begin
         nfail++;
         $display("FAIL %s actual=%0d expected<=%0d", tag, act, lim);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   endtask

   // shadow and model storage: index = {row[10:7], col[9:6]}
   logic [7:0] shadow [256];
   logic [7:0] cells  [256];
   logic [7:0] expq [$];

   logic [10:0] cur_row;
   logic [9:0]  cur_col;
   logic [7:0]  cur_wd;

   function automatic logic [20:0] mk_addr(input logic [3:0] rl, input logic [3:0] cl);
      return {rl, 7'h55, cl, 6'h2A};
   endfunction

   // DRAM model and timing monitor
   logic        ras_prev = 1'b1, cas_prev = 1'b1, we_prev = 1'b1, m_read = 1'b0;
   int          ras_run = 0, cas_run = 0, since_fall = 1000, acts = 0;
   logic [10:0] m_row = '0;
   logic [9:0]  m_col = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ras_prev = 1'b1; cas_prev = 1'b1; we_prev = 1'b1;
         ras_run = 0; cas_run = 1000; since_fall = 1000; m_read = 1'b0;
      end else begin
         since_fall++;
         if (dram_ras_n != ras_prev) begin
            if (!dram_ras_n) begin
               chk_ge("R3 precharge cycles", ras_run, T_RP);
               m_row = dram_addr;
               acts++;
            end else begin
               chk_ge("R3 ras low cycles", ras_run, T_RAS);
               chk_le("R4 ras low cycles", ras_run, RMAX);
            end
            ras_run = 1;
         end else ras_run++;
         if (!dram_ras_n && ras_run <= T_RAH)
            chk_eq("R5 row hold", int'(dram_addr), int'(m_row));
         if (dram_cas_n != cas_prev) begin
            if (!dram_cas_n) begin
               chk_ge("R5 ras-to-cas", ras_run - 1, T_RCD);
               chk_ge("R6 cas precharge", cas_run, T_CP);
               chk_ge("R6 cas period", since_fall - 1, T_PC);
               since_fall = 1;
               m_col = dram_addr[9:0];
               chk_eq("R2 row pins", int'(m_row), int'(cur_row));
               chk_eq("R2 col pins", int'(dram_addr), int'({1'b0, cur_col}));
               if (!dram_we_n) begin
                  chk_eq("R7 we setup", int'(we_prev), 0);
                  chk_eq("R7 dq drive", int'(dram_dq_oe), 1);
                  chk_eq("R7 oe high", int'(dram_oe_n), 1);
                  chk_eq("R7 write data", int'(dram_dq_out), int'(cur_wd));
                  cells[{m_row[10:7], m_col[9:6]}] = dram_dq_out;
                  m_read = 1'b0;
               end else begin
                  m_read = 1'b1;
                  dram_dq_in <= cells[{m_row[10:7], m_col[9:6]}] ^ 8'hFF;
               end
            end else begin
               chk_ge("R6 cas pulse", cas_run, T_CAS);
            end
            cas_run = 1;
         end else cas_run++;
         if (!dram_cas_n && m_read && cas_run >= T_CAS && ras_run >= T_RAC)
            dram_dq_in <= cells[{m_row[10:7], m_col[9:6]}];
         ras_prev = dram_ras_n;
         cas_prev = dram_cas_n;
         we_prev  = dram_we_n;
      end
   end

   // read return checking
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (expq.size() == 0) chk_eq("R8 unexpected read", 1, 0);
         else chk_eq("R8 read data", int'(rd_data), int'(expq.pop_front()));
      end
   end

   task automatic issue(input bit wr, input logic [3:0] rl, input logic [3:0] cl,
                        input logic [7:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = mk_addr(rl, cl); req_wdata = wd;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      cur_row = req_addr[20:10];
      cur_col = req_addr[9:0];
      cur_wd  = wd;
      if (wr) shadow[{rl, cl}] = wd;
      else    expq.push_back(shadow[{rl, cl}]);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   task automatic do_refresh(input bit park_req);
      @(negedge clk);
      ref_req = 1'b1;
      while (!ref_gnt) @(negedge clk);
      chk_eq("R12 ras at grant", int'(dram_ras_n), 1);
      chk_ge("R12 precharge before grant", ras_run, T_RP);
      if (park_req) begin
         req_valid = 1'b1; req_write = 1'b0; req_addr = mk_addr(4'h1, 4'h1);
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk_eq("R12 ready held off", int'(req_ready), 0);
            chk_eq("R12 ras held high", int'(dram_ras_n), 1);
         end
         req_valid = 1'b0;
      end
      ref_req = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 400 && expq.size() != 0; i++) @(negedge clk);
      chk_eq("R8 all reads returned", expq.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int seed_dummy;
      int a0;
      logic [3:0] hot;
      seed_dummy = $urandom(32'h0ED0);
      for (int i = 0; i < 256; i++) begin
         shadow[i] = 8'(i * 37) ^ 8'h5A;
         cells[i]  = 8'(i * 37) ^ 8'h5A;
      end
      cur_row = '0; cur_col = '0; cur_wd = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_eq("R1 ras_n", int'(dram_ras_n), 1);
      chk_eq("R1 cas_n", int'(dram_cas_n), 1);
      chk_eq("R1 we_n", int'(dram_we_n), 1);
      chk_eq("R1 oe_n", int'(dram_oe_n), 1);
      chk_eq("R1 dq_oe", int'(dram_dq_oe), 0);
      chk_eq("R1 rd_valid", int'(rd_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_eq("R1 ready after reset", int'(req_ready), 0);

      // R9 page hits share one activation
      a0 = acts;
      issue(1'b1, 4'h3, 4'h1, 8'hC3);
      issue(1'b0, 4'h3, 4'h1, 8'h00);
      issue(1'b1, 4'h3, 4'hF, 8'h3C);
      drain();
      chk_eq("R9 one activation for page hits", acts - a0, 1);

      // R10 row miss reopens
      a0 = acts;
      issue(1'b0, 4'h5, 4'hF, 8'h00);
      issue(1'b0, 4'h3, 4'hF, 8'h00);
      drain();
      chk_eq("R10 activations on row misses", acts - a0, 2);

      // R11 idle page closes itself
      repeat (120) @(negedge clk);
      chk_eq("R11 idle page closed", int'(dram_ras_n), 1);
      a0 = acts;
      for (int i = 0; i < 20; i++) issue(1'b0, 4'h7, 4'(i), 8'h00);
      drain();
      chk_ge("R11 long burst split", acts - a0, 2);

      // R12 refresh with open page and a parked request
      issue(1'b1, 4'h2, 4'h2, 8'h99);
      do_refresh(1'b1);
      issue(1'b0, 4'h2, 4'h2, 8'h00);
      drain();
      do_refresh(1'b0);

      // corner rows and columns
      issue(1'b1, 4'hF, 4'hF, 8'hFF);
      issue(1'b1, 4'h0, 4'h0, 8'h00);
      issue(1'b0, 4'hF, 4'hF, 8'h00);
      issue(1'b0, 4'h0, 4'h0, 8'h00);
      drain();

      // constrained random traffic
      hot = 4'h9;
      for (int n = 0; n < 300; n++) begin
         logic [3:0] rl;
         if (($urandom % 8) == 0) hot = 4'($urandom);
         rl = (($urandom % 4) == 0) ? 4'($urandom) : hot;
         issue(1'($urandom), rl, 4'($urandom), 8'($urandom));
         repeat ($urandom % 4) @(negedge clk);
         if (($urandom % 30) == 0) do_refresh(1'b0);
      end
      drain();
      finish_run();
   end

endmodule